// File: doc/BRIEF.md
# Polled Keyboard and Display Register Block

This block sits on a simple single-cycle host bus and presents two character devices to software: an input channel fed by a keyboard-side byte strobe, and an output channel that hands one byte at a time to a display. Each channel shows up as a control word and a data word. Together they form four 32-bit registers at fixed, word-aligned addresses at the top of the address space.

Software can busy-wait on a channel. It reads the control word, tests the ready bit, and loops until the bit is set. It then reads the arrived keystroke or writes the next character. A per-channel enable bit turns a set ready flag into an interrupt request instead. The device ends of the block are small. A valid pulse with a byte delivers a keystroke. The display sees the latched byte and a pending flag, and pulses a done strobe once it has taken the byte.

Top module: `kd_mmio_ctrl`

## Requirements
- R1: Exact 32-bit address equality selects a register. 0xFFFF0000 is the keyboard control word, 0xFFFF0004 is keyboard data, 0xFFFF0008 is display control and 0xFFFF000C is display data. Read data is combinational and valid in the same cycle as `bus_rd`.
- R2: A control word reads with the ready flag in bit 0, the interrupt enable in bit 1 and zeros in bits 31:2. A data word reads with its byte in bits 7:0 and zeros above.
- R3: A cycle with `kbd_valid` high captures `kbd_byte` and sets the keyboard ready flag at the next clock edge. If a keyboard data read happens in the same cycle, the read returns the previous byte and the flag ends set.
- R4: A read of keyboard data clears the keyboard ready flag at the next edge. A read of either control word changes nothing.
- R5: The display ready flag is 1 after reset. A display data write latches `bus_wdata[7:0]` onto `disp_byte` and clears the flag. `disp_pend` is the inverse of the flag. A `disp_done` pulse sets the flag, except when a display data write happens in the same cycle, in which case the write wins.
- R6: A write to a control word loads its interrupt enable from `bus_wdata[1]` and leaves the ready flag unchanged. Writes to keyboard data are ignored.
- R7: `irq` is high exactly when some channel has both its ready flag and its interrupt enable set. It follows the flags with no extra register.
- R8: Any address other than the four exact register addresses, unaligned ones included, reads as zero, and writes to it change nothing.
- R9: Synchronous active-high reset clears both interrupt enables, the keyboard ready flag, both held bytes and `irq`, and sets the display ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Host byte address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, zero when no register is selected |
| kbd_valid | input | 1 | Keyboard byte strobe |
| kbd_byte | input | 8 | Keyboard byte, sampled while kbd_valid is high |
| disp_byte | output | 8 | Byte most recently written for the display |
| disp_pend | output | 1 | High while the display has not yet taken disp_byte |
| disp_done | input | 1 | Display has consumed the pending byte |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the same cycle the read strobe is high, so the scoreboard monitor compares it 2 ns after the falling edge on which the driver raised the strobe. Every side effect (a flag set or cleared, an enable loaded, a byte latched) lands on the following rising edge. The bench therefore checks those effects only on a later access or a later falling-edge sample, never in the cycle of the stimulus. The interrupt output follows the flags combinationally, so it is sampled one falling edge after the stimulus that moved a flag or an enable.

// File: rtl/kd_pkg.sv
package kd_pkg;
    parameter int unsigned BUS_W    = 32;
    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned NUM_REGS = 4;
    parameter int unsigned RDY_BIT  = 0;
    parameter int unsigned IE_BIT   = 1;

    // register slots in address order: slot i sits at base + 4*i
    typedef enum logic [1:0] {
        SLOT_KCTL = 2'd0,
        SLOT_KDAT = 2'd1,
        SLOT_DCTL = 2'd2,
        SLOT_DDAT = 2'd3
    } slot_e;

    typedef struct packed {
        logic ie;
        logic rdy;
    } ctl_bits_t;

    function automatic logic [BUS_W-1:0] ctl_word(input ctl_bits_t c);
        return {{(BUS_W-2){1'b0}}, c.ie, c.rdy};
    endfunction

    function automatic logic [BUS_W-1:0] dat_word(input logic [BYTE_W-1:0] b);
        return {{(BUS_W-BYTE_W){1'b0}}, b};
    endfunction
endpackage

// File: rtl/kd_addr_decode.sv
module kd_addr_decode #(
    parameter int unsigned          ADDR_W = 32,
    parameter int unsigned          N      = 4,
    parameter int unsigned          STRIDE = 4,
    parameter logic [ADDR_W-1:0]    BASE   = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      hit
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE + ADDR_W'(i * STRIDE);
        assign hit[i] = (addr == SLOT_ADDR);
    end
endmodule

// File: rtl/kd_channel.sv
module kd_channel #(
    parameter int unsigned BYTE_W   = 8,
    parameter bit          RST_RDY  = 1'b0,
    parameter bit          SET_WINS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ie_we_i,
    input  logic              ie_d_i,
    output logic              rdy_o,
    output logic              ie_o,
    output logic [BYTE_W-1:0] byte_o
);
    logic rdy_q, rdy_n, ie_q;
    logic [BYTE_W-1:0] byte_q;

    if (SET_WINS) begin : g_set_wins
        always_comb begin
            rdy_n = rdy_q;
            if (clr_i) rdy_n = 1'b0;
            if (set_i) rdy_n = 1'b1;
        end
    end else begin : g_clr_wins
        always_comb begin
            rdy_n = rdy_q;
            if (set_i) rdy_n = 1'b1;
            if (clr_i) rdy_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= RST_RDY;
            ie_q   <= 1'b0;
            byte_q <= '0;
        end else begin
            rdy_q <= rdy_n;
            if (ie_we_i) ie_q   <= ie_d_i;
            if (load_i)  byte_q <= byte_i;
        end
    end

    assign rdy_o  = rdy_q;
    assign ie_o   = ie_q;
    assign byte_o = byte_q;
endmodule

// File: rtl/kd_mmio_ctrl.sv
module kd_mmio_ctrl
    import kd_pkg::*;
#(
    parameter int unsigned       ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              kbd_valid,
    input  logic [BYTE_W-1:0] kbd_byte,
    output logic [BYTE_W-1:0] disp_byte,
    output logic              disp_pend,
    input  logic              disp_done,
    output logic              irq
);
    localparam int unsigned STRIDE = BUS_W / 8;

    logic [NUM_REGS-1:0] hit;
    logic kbd_rdy, kbd_ie, disp_rdy, disp_ie;
    logic [BYTE_W-1:0] kbd_held;
    logic kdat_rd, ddat_wr;
    logic unused_wdata_bits;

    kd_addr_decode #(
        .ADDR_W(ADDR_W), .N(NUM_REGS), .STRIDE(STRIDE), .BASE(BASE)
    ) u_dec (
        .addr(bus_addr),
        .hit (hit)
    );

    assign kdat_rd = bus_rd & hit[SLOT_KDAT];
    assign ddat_wr = bus_wr & hit[SLOT_DDAT];

    kd_channel #(.BYTE_W(BYTE_W), .RST_RDY(1'b0), .SET_WINS(1'b1)) u_kbd (
        .clk    (clk),
        .rst    (rst),
        .set_i  (kbd_valid),
        .clr_i  (kdat_rd),
        .load_i (kbd_valid),
        .byte_i (kbd_byte),
        .ie_we_i(bus_wr & hit[SLOT_KCTL]),
        .ie_d_i (bus_wdata[IE_BIT]),
        .rdy_o  (kbd_rdy),
        .ie_o   (kbd_ie),
        .byte_o (kbd_held)
    );

    kd_channel #(.BYTE_W(BYTE_W), .RST_RDY(1'b1), .SET_WINS(1'b0)) u_disp (
        .clk    (clk),
        .rst    (rst),
        .set_i  (disp_done),
        .clr_i  (ddat_wr),
        .load_i (ddat_wr),
        .byte_i (bus_wdata[BYTE_W-1:0]),
        .ie_we_i(bus_wr & hit[SLOT_DCTL]),
        .ie_d_i (bus_wdata[IE_BIT]),
        .rdy_o  (disp_rdy),
        .ie_o   (disp_ie),
        .byte_o (disp_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit[SLOT_KCTL]) bus_rdata = ctl_word('{ie: kbd_ie,  rdy: kbd_rdy});
        if (hit[SLOT_KDAT]) bus_rdata = dat_word(kbd_held);
        if (hit[SLOT_DCTL]) bus_rdata = ctl_word('{ie: disp_ie, rdy: disp_rdy});
        if (hit[SLOT_DDAT]) bus_rdata = dat_word(disp_byte);
    end

    assign disp_pend = ~disp_rdy;
    assign irq       = (kbd_rdy & kbd_ie) | (disp_rdy & disp_ie);
    assign unused_wdata_bits = ^bus_wdata;
endmodule

// File: rtl/kd_mmio_ctrl_chk.sv
module kd_mmio_ctrl_chk #(
    parameter int unsigned       ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000,
    parameter int unsigned       BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              kbd_valid,
    input logic              disp_done,
    input logic [BYTE_W-1:0] disp_byte,
    input logic              irq,
    input logic              kbd_rdy,
    input logic              kbd_ie,
    input logic              disp_rdy,
    input logic              disp_ie
);
    logic at_kctl, at_kdat, at_dctl, at_ddat, in_map;
    assign at_kctl = bus_addr == BASE;
    assign at_kdat = bus_addr == BASE + ADDR_W'(4);
    assign at_dctl = bus_addr == BASE + ADDR_W'(8);
    assign at_ddat = bus_addr == BASE + ADDR_W'(12);
    assign in_map  = at_kctl | at_kdat | at_dctl | at_ddat;

    p_kbd_set_r3: assert property (@(posedge clk) disable iff (rst)
        kbd_valid |=> kbd_rdy) else $error("p_kbd_set_r3");

    p_kbd_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && at_kdat && !kbd_valid) |=> !kbd_rdy) else $error("p_kbd_clr_r4");

    p_disp_wr_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_ddat) |=> (!disp_rdy && disp_byte == $past(bus_wdata[BYTE_W-1:0])))
        else $error("p_disp_wr_r5");

    p_disp_done_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_done && !(bus_wr && at_ddat)) |=> disp_rdy) else $error("p_disp_done_r5");

    p_ctl_ro_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_kctl && !kbd_valid) |=> ($stable(kbd_rdy) && kbd_ie == $past(bus_wdata[1])))
        else $error("p_ctl_ro_r6");

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!kbd_ie && !disp_ie) |-> !irq) else $error("p_irq_quiet_r7");

    p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
        ((kbd_rdy && kbd_ie) || (disp_rdy && disp_ie)) |-> irq) else $error("p_irq_raise_r7");

    p_outside_r8: assert property (@(posedge clk) disable iff (rst)
        !in_map |-> (bus_rdata == 32'h0)) else $error("p_outside_r8");
endmodule

bind kd_mmio_ctrl kd_mmio_ctrl_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .BYTE_W(kd_pkg::BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid),
    .disp_done(disp_done),
    .disp_byte(disp_byte),
    .irq      (irq),
    .kbd_rdy  (kbd_rdy),
    .kbd_ie   (kbd_ie),
    .disp_rdy (disp_rdy),
    .disp_ie  (disp_ie)
);

// File: tb/kd_mmio_ctrl_bench.sv
module kd_mmio_ctrl_bench;
    localparam logic [31:0] A_KCTL = 32'hFFFF_0000;
    localparam logic [31:0] A_KDAT = 32'hFFFF_0004;
    localparam logic [31:0] A_DCTL = 32'hFFFF_0008;
    localparam logic [31:0] A_DDAT = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic [7:0]  disp_byte;
    logic        disp_pend;
    logic        disp_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    kd_mmio_ctrl u_kd_mmio_ctrl (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
        .disp_byte(disp_byte), .disp_pend(disp_pend),
        .disp_done(disp_done), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read cycle
    always @(negedge clk) begin
        #2;
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R1: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic bus_read(input logic [31:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        sb_q.push_back('{exp: e, tag: tag});
        @(negedge clk);
        bus_rd = 1'b0;
        bus_addr = '0;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = '0;
    endtask

    task automatic kbd_push(input logic [7:0] b);
        @(negedge clk);
        kbd_valid = 1'b1;
        kbd_byte = b;
        @(negedge clk);
        kbd_valid = 1'b0;
    endtask

    task automatic disp_take();
        @(negedge clk);
        disp_done = 1'b1;
        @(negedge clk);
        disp_done = 1'b0;
    endtask

    task automatic port_sample(input logic [31:0] act_sel, input logic [31:0] exp, input string tag);
        check(act_sel, exp, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        @(negedge clk); #3;
        port_sample({31'b0, irq}, 32'h0, "R9 irq");
        port_sample({31'b0, disp_pend}, 32'h0, "R9 disp_pend");
        bus_read(A_KCTL, 32'h0, "R9 kbd ctrl");
        bus_read(A_KDAT, 32'h0, "R9 kbd data");
        bus_read(A_DCTL, 32'h1, "R9 disp ctrl");

        // R3 arrival, R1/R2 data layout, R4 clear on data read
        kbd_push(8'h41);
        bus_read(A_KCTL, 32'h1, "R3 ready set");
        bus_read(A_KCTL, 32'h1, "R4 ctrl read no effect");
        bus_read(A_KDAT, 32'h41, "R1 kbd data");
        bus_read(A_KCTL, 32'h0, "R4 ready cleared");

        // R6 control write: only IE moves
        bus_write(A_KCTL, 32'hFFFF_FFFF);
        bus_read(A_KCTL, 32'h2, "R6 ie set ready kept");
        @(negedge clk); #3;
        port_sample({31'b0, irq}, 32'h0, "R7 ie without ready");
        kbd_push(8'h5A);
        @(negedge clk); #3;
        port_sample({31'b0, irq}, 32'h1, "R7 kbd irq");
        bus_read(A_KCTL, 32'h3, "R2 ctrl word");

        // R6 keyboard data write ignored
        bus_write(A_KDAT, 32'h0000_0077);
        bus_read(A_KDAT, 32'h5A, "R6 kbd data write ignored");

        // R3 tie: read and arrival together
        @(negedge clk);
        bus_addr = A_KDAT;
        bus_rd = 1'b1;
        kbd_valid = 1'b1;
        kbd_byte = 8'h33;
        sb_q.push_back('{exp: 32'h5A, tag: "R3 tie old byte"});
        @(negedge clk);
        bus_rd = 1'b0;
        kbd_valid = 1'b0;
        bus_addr = '0;
        bus_read(A_KCTL, 32'h3, "R3 tie arrival wins");
        bus_read(A_KDAT, 32'h33, "R3 tie new byte");
        bus_read(A_KCTL, 32'h2, "R4 cleared after tie");

        bus_write(A_KCTL, 32'h0);
        @(negedge clk); #3;
        port_sample({31'b0, irq}, 32'h0, "R7 ie cleared");

        // R5 display path
        bus_write(A_DDAT, 32'h0000_01C5);
        @(negedge clk); #3;
        port_sample({24'b0, disp_byte}, 32'hC5, "R5 disp byte");
        port_sample({31'b0, disp_pend}, 32'h1, "R5 pending");
        bus_read(A_DCTL, 32'h0, "R5 ready cleared");
        bus_read(A_DDAT, 32'hC5, "R2 disp data");
        bus_write(A_DCTL, 32'h0000_0003);
        bus_read(A_DCTL, 32'h2, "R6 disp ie only");
        @(negedge clk); #3;
        port_sample({31'b0, irq}, 32'h0, "R7 disp not ready");
        disp_take();
        @(negedge clk); #3;
        port_sample({31'b0, irq}, 32'h1, "R7 disp irq");
        port_sample({31'b0, disp_pend}, 32'h0, "R5 consumed");
        bus_read(A_DCTL, 32'h3, "R5 ready set");

        // R5 tie: write and done together, write wins
        @(negedge clk);
        bus_addr = A_DDAT;
        bus_wdata = 32'h0000_0099;
        bus_wr = 1'b1;
        disp_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        disp_done = 1'b0;
        bus_addr = '0;
        bus_read(A_DCTL, 32'h2, "R5 tie write wins");
        @(negedge clk); #3;
        port_sample({24'b0, disp_byte}, 32'h99, "R5 tie byte");

        // R8 outside the map
        bus_read(32'hFFFF_0010, 32'h0, "R8 past window");
        bus_read(32'hFFFF_0001, 32'h0, "R8 unaligned");
        bus_read(32'h0000_000C, 32'h0, "R8 low address");
        bus_write(32'hFFFF_0009, 32'h0);
        bus_write(32'hFFFF_000D, 32'h0000_0011);
        bus_read(A_DCTL, 32'h2, "R8 unaligned write ignored");
        @(negedge clk); #3;
        port_sample({24'b0, disp_byte}, 32'h99, "R8 disp byte kept");

        repeat (2) @(negedge clk);
        #3;
        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1: actual %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule